// File: doc/BRIEF.md
# Flash Plane Operation Scheduler

This block sits between a command source and a flash array made of gangs of packages. Each command asks for a read, a program or an erase on one plane. The command names that plane by gang, package, die and plane index. Commands enter a small in-order queue through a valid/ready handshake. Each cycle the scheduler looks through the queue from oldest to youngest. It starts the first command that the array's concurrency rules allow, and it starts at most one command per cycle.

The concurrency rules are as follows:
- A plane runs one operation at a time.
- The two dies of a package run independently of each other.
- Inside a die, only the pairs {0,2} and {1,3} may be busy together.
- Within one gang, only one package may have work in flight.
- Packages in different gangs may run in parallel.

A younger command may pass an older one that is blocked. Two commands for the same plane always keep their order.

Each started operation loads a per-plane busy timer with a preset that depends on the operation. Erase takes longest, program is in the middle and read is shortest. When the timer runs out, the command's tag is returned on a single-cycle done strobe. If the command names a die or plane index that does not exist, or uses the reserved operation code, it touches no plane and is returned with an error flag.

Top module: `fps_plane_sched`

## Requirements
- R1: `cmd_ready` is high exactly when fewer than QUEUE_DEPTH commands wait in the queue. After reset it is high.
- R2: A command to an idle, unconflicted plane produces exactly one `done_valid` pulse carrying its tag with `done_err`=0. The pulse comes T+2 cycles after the accepting clock edge. T is T_READ for op code 2'b00, T_PROG for 2'b01 and T_ERASE for 2'b10.
- R3: Commands to the same plane run one after another in arrival order. The second one's done comes T+2 cycles after the first one's done.
- R4: Planes 0 and 2 of one die (likewise 1 and 3) may be busy at the same time. A command to the partner plane of a busy plane still completes T+2 cycles after acceptance.
- R5: Any other pair of planes in one die (for example 0 and 1) never runs together. The blocked command's done comes T+2 cycles after the blocking command's done.
- R6: The two dies of a package run concurrently.
- R7: Within a gang, at most one package has an operation in flight. A blocked command completes T+2 cycles after the blocker's done. Packages in different gangs run concurrently.
- R8: A younger command whose plane is free is started ahead of an older command that is blocked.
- R9: A command is rejected if its die index is at least DIES_PER_PKG, its plane index is at least PLANES_PER_DIE, or its op code is 2'b11. A rejected command returns its tag with `done_err`=1, two cycles after acceptance when the queue is otherwise empty. It leaves every plane untouched.
- R10: Reset empties the queue and clears all busy timers. No completion is reported afterwards for work that was dropped, and a freshly reset plane accepts new work at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue has room |
| cmd_op | input | 2 | 00 read, 01 program, 10 erase, 11 reserved |
| cmd_gang | input | GANG_W | Gang index |
| cmd_pkg | input | PKG_W | Package index within the gang |
| cmd_die | input | DIE_SEL_W | Die index within the package |
| cmd_plane | input | PLANE_SEL_W | Plane index within the die |
| cmd_tag | input | TAG_W | Tag returned on completion |
| done_valid | output | 1 | One-cycle completion strobe |
| done_tag | output | TAG_W | Tag of the completed command |
| done_err | output | 1 | Completion is a rejection |

## Verification
Suppose a plane timer is miscounted, or a plane's busy flag is left stale. The fault shows on the very next completion for that plane: the done strobe moves away from its T+2 slot, or it never comes. A pairing or gang check that is wrong in the permissive direction lets a blocked command finish about T+2 cycles early. One that is wrong in the strict direction pushes a command that should run concurrently one whole operation late. The bench therefore measures every done against the accepting edge or against the blocking command's done, exactly to the cycle. Reset faults show as stray completions during a quiet window after reset.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PL_IDLE = 2'd0,
        PL_BUSY = 2'd1,
        PL_PEND = 2'd2
    } pl_state_e;
endpackage

// File: rtl/fps_plane_timer.sv
module fps_plane_timer #(
    parameter int CNT_W = 12,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             clear_i,
    output logic             occupied_o,
    output logic             pending_o,
    output logic [TAG_W-1:0] tag_o
);
    import fps_pkg::*;

    typedef struct packed {
        pl_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [TAG_W-1:0] tag;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        case (tmr_q.st)
            PL_IDLE: if (start_i) begin
                tmr_d.st  = PL_BUSY;
                tmr_d.cnt = preset_i;
                tmr_d.tag = tag_i;
            end
            PL_BUSY: begin
                if (tmr_q.cnt <= CNT_W'(1)) tmr_d.st = PL_PEND;
                else                        tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
            PL_PEND: if (clear_i) tmr_d.st = PL_IDLE;
            default: tmr_d.st = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign occupied_o = (tmr_q.st != PL_IDLE);
    assign pending_o  = (tmr_q.st == PL_PEND);
    assign tag_o      = tmr_q.tag;

    // R3: a plane is only ever started while it holds no operation
    a_r3_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !occupied_o);

    // R2: busy time counts down by one per cycle
    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.st == PL_BUSY && tmr_q.cnt > CNT_W'(1)) |=>
        (tmr_q.st == PL_BUSY && tmr_q.cnt == CNT_W'($past(tmr_q.cnt) - 1'b1)));
endmodule

// File: rtl/fps_cmd_queue.sv
module fps_cmd_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 10,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_i,
    input  logic [W-1:0]              push_data_i,
    input  logic                      pop_i,
    input  logic [IDX_W-1:0]          pop_idx_i,
    output logic [DEPTH-1:0][W-1:0]   data_o,
    output logic [DEPTH-1:0]          valid_o,
    output logic                      ready_o
);
    typedef struct packed {
        logic [DEPTH-1:0]        vld;
        logic [DEPTH-1:0][W-1:0] dat;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        int n;
        q_d = q_q;
        // close the gap left by the removed entry, keeping age order
        for (int k = 0; k < DEPTH; k++) begin
            if (pop_i && k >= int'(pop_idx_i)) begin
                if (k < DEPTH - 1) begin
                    q_d.vld[k] = q_q.vld[k+1];
                    q_d.dat[k] = q_q.dat[k+1];
                end else begin
                    q_d.vld[k] = 1'b0;
                end
            end
        end
        n = $countones(q_d.vld);
        for (int k = 0; k < DEPTH; k++) begin
            if (push_i && k == n) begin
                q_d.vld[k] = 1'b1;
                q_d.dat[k] = push_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign data_o  = q_q.dat;
    assign valid_o = q_q.vld;
    assign ready_o = !(&q_q.vld);

    // R1: no push is ever accepted into a full queue
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (&q_q.vld) |-> !(push_i && !pop_i));
endmodule

// File: rtl/fps_plane_sched.sv
module fps_plane_sched #(
    parameter int NUM_GANGS      = 2,
    parameter int PKGS_PER_GANG  = 2,
    parameter int DIES_PER_PKG   = 2,
    parameter int PLANES_PER_DIE = 4,
    parameter int DIE_SEL_W      = 2,
    parameter int PLANE_SEL_W    = 3,
    parameter int TAG_W          = 4,
    parameter int QUEUE_DEPTH    = 4,
    parameter int T_READ         = 50,
    parameter int T_PROG         = 500,
    parameter int T_ERASE        = 3000,
    localparam int GANG_W = (NUM_GANGS > 1) ? $clog2(NUM_GANGS) : 1,
    localparam int PKG_W  = (PKGS_PER_GANG > 1) ? $clog2(PKGS_PER_GANG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_op,
    input  logic [GANG_W-1:0]      cmd_gang,
    input  logic [PKG_W-1:0]       cmd_pkg,
    input  logic [DIE_SEL_W-1:0]   cmd_die,
    input  logic [PLANE_SEL_W-1:0] cmd_plane,
    input  logic [TAG_W-1:0]       cmd_tag,
    output logic                   done_valid,
    output logic [TAG_W-1:0]       done_tag,
    output logic                   done_err
);
    import fps_pkg::*;

    localparam int NPKG     = NUM_GANGS * PKGS_PER_GANG;
    localparam int PKG_SPAN = DIES_PER_PKG * PLANES_PER_DIE;
    localparam int GNG_SPAN = PKGS_PER_GANG * PKG_SPAN;
    localparam int NPL      = NPKG * PKG_SPAN;
    localparam int PL_W     = (NPL > 1) ? $clog2(NPL) : 1;
    localparam int T_MAX    = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                                 : ((T_PROG > T_READ) ? T_PROG : T_READ);
    localparam int CNT_W    = $clog2(T_MAX + 1);
    localparam int QW       = 1 + PL_W + 2 + TAG_W;
    localparam int ERR_POS  = QW - 1;
    localparam int FLAT_LSB = TAG_W + 2;
    localparam int IDX_W    = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
    localparam int HALF     = PLANES_PER_DIE / 2;

    typedef struct packed {
        logic             err_vld;
        logic [TAG_W-1:0] err_tag;
        logic             done_vld;
        logic             done_err;
        logic [TAG_W-1:0] done_tag;
    } sched_t;

    sched_t s_d, s_q;

    logic [QUEUE_DEPTH-1:0][QW-1:0] q_dat;
    logic [QUEUE_DEPTH-1:0]         q_vld;
    logic                           q_pop;
    logic [IDX_W-1:0]               q_pop_idx;
    logic [QW-1:0]                  push_ent;
    logic [NPL-1:0]                 occ, pend, start, clear;
    logic [TAG_W-1:0]               ptag [NPL];
    logic [CNT_W-1:0]               start_preset;
    logic [TAG_W-1:0]               start_tag;

    // build the queue entry: reject flag, flat plane index, op, tag
    always_comb begin
        logic bad;
        bad = (cmd_op == OP_RSVD) || (int'(cmd_gang) >= NUM_GANGS) ||
              (int'(cmd_pkg) >= PKGS_PER_GANG) || (int'(cmd_die) >= DIES_PER_PKG) ||
              (int'(cmd_plane) >= PLANES_PER_DIE);
        push_ent = {bad,
                    bad ? PL_W'(0) : PL_W'(((int'(cmd_gang) * PKGS_PER_GANG + int'(cmd_pkg))
                                     * DIES_PER_PKG + int'(cmd_die)) * PLANES_PER_DIE
                                     + int'(cmd_plane)),
                    cmd_op, cmd_tag};
    end

    fps_cmd_queue #(.DEPTH(QUEUE_DEPTH), .W(QW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_i(cmd_valid && cmd_ready), .push_data_i(push_ent),
        .pop_i(q_pop), .pop_idx_i(q_pop_idx),
        .data_o(q_dat), .valid_o(q_vld), .ready_o(cmd_ready)
    );

    for (genvar f = 0; f < NPL; f++) begin : g_plane
        fps_plane_timer #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .start_i(start[f]), .preset_i(start_preset), .tag_i(start_tag),
            .clear_i(clear[f]),
            .occupied_o(occ[f]), .pending_o(pend[f]), .tag_o(ptag[f])
        );
    end

    always_comb begin
        logic [NPL-1:0]  ok_pl;
        logic            found, blocked, picked, e_err;
        logic [PL_W-1:0] e_flat;
        logic [1:0]      e_op;
        s_d          = s_q;
        s_d.done_vld = 1'b0;
        s_d.done_err = 1'b0;
        start        = '0;
        clear        = '0;
        q_pop        = 1'b0;
        q_pop_idx    = '0;
        start_preset = CNT_W'(T_READ);
        start_tag    = '0;
        found        = 1'b0;
        picked       = 1'b0;

        // which planes could legally start now
        for (int f = 0; f < NPL; f++) begin
            ok_pl[f] = !occ[f];
            for (int g = 0; g < NPL; g++) begin
                if (g != f && occ[g]) begin
                    if ((g / PLANES_PER_DIE) == (f / PLANES_PER_DIE) &&
                        (g % PLANES_PER_DIE) != ((f % PLANES_PER_DIE) ^ HALF))
                        ok_pl[f] = 1'b0;
                    if ((g / GNG_SPAN) == (f / GNG_SPAN) && (g / PKG_SPAN) != (f / PKG_SPAN))
                        ok_pl[f] = 1'b0;
                end
            end
        end

        // oldest-first scan, one start per cycle, same-plane order kept
        for (int i = 0; i < QUEUE_DEPTH; i++) begin
            e_err  = q_dat[i][ERR_POS];
            e_flat = q_dat[i][FLAT_LSB +: PL_W];
            e_op   = q_dat[i][TAG_W +: 2];
            blocked = 1'b0;
            for (int j = 0; j < i; j++)
                if (q_vld[j] && !q_dat[j][ERR_POS] && q_dat[j][FLAT_LSB +: PL_W] == e_flat)
                    blocked = 1'b1;
            if (q_vld[i] && !found) begin
                if (e_err ? !s_q.err_vld : (ok_pl[e_flat] && !blocked)) begin
                    found     = 1'b1;
                    q_pop     = 1'b1;
                    q_pop_idx = IDX_W'(i);
                    start_tag = q_dat[i][TAG_W-1:0];
                    case (e_op)
                        OP_PROG:  start_preset = CNT_W'(T_PROG);
                        OP_ERASE: start_preset = CNT_W'(T_ERASE);
                        default:  start_preset = CNT_W'(T_READ);
                    endcase
                    if (e_err) begin
                        s_d.err_vld = 1'b1;
                        s_d.err_tag = q_dat[i][TAG_W-1:0];
                    end else begin
                        start[e_flat] = 1'b1;
                    end
                end
            end
        end

        // completion port: rejection first, then lowest finished plane
        if (s_q.err_vld) begin
            s_d.err_vld  = 1'b0;
            s_d.done_vld = 1'b1;
            s_d.done_err = 1'b1;
            s_d.done_tag = s_q.err_tag;
        end else begin
            for (int f = 0; f < NPL; f++) begin
                if (!picked && pend[f]) begin
                    picked       = 1'b1;
                    clear[f]     = 1'b1;
                    s_d.done_vld = 1'b1;
                    s_d.done_tag = ptag[f];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_valid = s_q.done_vld;
    assign done_tag   = s_q.done_tag;
    assign done_err   = s_q.done_err;

    // R4/R5: inside a die only partner planes may be occupied together
    for (genvar d = 0; d < NPKG * DIES_PER_PKG; d++) begin : g_die_chk
        for (genvar a = 0; a < PLANES_PER_DIE; a++) begin : g_a
            for (genvar b = a + 1; b < PLANES_PER_DIE; b++) begin : g_b
                if (b != (a ^ HALF)) begin : g_bad_pair
                    a_r5_no_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
                        !(occ[d*PLANES_PER_DIE + a] && occ[d*PLANES_PER_DIE + b]));
                end
            end
        end
    end

    // R7: at most one package of a gang holds work
    logic [NPKG-1:0] pkg_act;
    for (genvar k = 0; k < NPKG; k++) begin : g_pkg_act
        assign pkg_act[k] = |occ[k*PKG_SPAN +: PKG_SPAN];
    end
    for (genvar g = 0; g < NUM_GANGS; g++) begin : g_gang_chk
        a_r7_gang_serial: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pkg_act[g*PKGS_PER_GANG +: PKGS_PER_GANG]));
    end

    // R9: a rejection never starts a plane timer
    a_r9_reject_no_plane: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.err_vld) |-> $stable(occ) || !$past(|start));
endmodule

// File: tb/fps_plane_sched_tb_top.sv
module fps_plane_sched_tb_top;
    localparam int TR = 50, TP = 500, TE = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = '0;
    logic [0:0] cmd_gang = '0;
    logic [0:0] cmd_pkg = '0;
    logic [1:0] cmd_die = '0;
    logic [2:0] cmd_plane = '0;
    logic [3:0] cmd_tag = '0;
    logic       done_valid;
    logic [3:0] done_tag;
    logic       done_err;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    int done_cnt = 0;
    int done_cyc [16];
    bit done_e [16];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fps_plane_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_gang(cmd_gang), .cmd_pkg(cmd_pkg), .cmd_die(cmd_die),
        .cmd_plane(cmd_plane), .cmd_tag(cmd_tag), .done_valid(done_valid),
        .done_tag(done_tag), .done_err(done_err)
    );

    always @(negedge clk) begin
        if (rst_n && done_valid) begin
            done_cyc[done_tag] = cyc;
            done_e[done_tag]   = done_err;
            done_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int t = 0; t < 16; t++) begin
            done_cyc[t] = -1;
            done_e[t]   = 1'b0;
        end
    endtask

    task automatic send(input logic [1:0] op, input int g, input int p, input int d,
                        input int pl, input int tag, output int acc);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_gang  = 1'(g);
        cmd_pkg   = 1'(p);
        cmd_die   = 2'(d);
        cmd_plane = 3'(pl);
        cmd_tag   = 4'(tag);
        @(posedge clk);
        #1;
        acc = cyc;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_tag(input int tag);
        int n = 0;
        while (done_cyc[tag] < 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (done_cyc[tag] < 0) begin
            nchk++;
            nerr++;
            $display("FAIL timeout: tag %0d actual %0d expected %0d", tag, 0, 1);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R1 ready after reset", int'(cmd_ready), 1);
        check("R10 no done after reset", int'(done_valid), 0);
    endtask

    task automatic t_single();
        int a, n0;
        clear_log();
        n0 = done_cnt;
        send(2'b00, 0, 0, 0, 0, 1, a); wait_tag(1);
        check("R2 read latency", done_cyc[1] - a, TR + 2);
        check("R2 read err flag", int'(done_e[1]), 0);
        send(2'b01, 0, 0, 0, 1, 2, a); wait_tag(2);
        check("R2 program latency", done_cyc[2] - a, TP + 2);
        send(2'b10, 1, 1, 1, 3, 3, a); wait_tag(3);
        check("R2 erase latency", done_cyc[3] - a, TE + 2);
        check("R2 one pulse per command", done_cnt - n0, 3);
    endtask

    task automatic t_same_plane();
        int a, b;
        clear_log();
        send(2'b00, 0, 0, 0, 0, 4, a);
        send(2'b00, 0, 0, 0, 0, 5, b);
        wait_tag(5);
        check("R3 first latency", done_cyc[4] - a, TR + 2);
        check("R3 second after first", done_cyc[5] - done_cyc[4], TR + 2);
    endtask

    task automatic t_pair();
        int a, b;
        clear_log();
        send(2'b00, 0, 0, 0, 0, 6, a);
        send(2'b00, 0, 0, 0, 2, 7, b);
        wait_tag(7); wait_tag(6);
        check("R4 partner plane concurrent", done_cyc[7] - b, TR + 2);
        clear_log();
        send(2'b01, 0, 0, 1, 3, 8, a);
        send(2'b00, 0, 0, 1, 1, 9, b);
        wait_tag(8); wait_tag(9);
        check("R4 planes 3 and 1 concurrent", done_cyc[9] - b, TR + 2);
    endtask

    task automatic t_nonpair();
        int a, b;
        clear_log();
        send(2'b00, 0, 0, 0, 0, 8, a);
        send(2'b00, 0, 0, 0, 1, 9, b);
        wait_tag(9);
        check("R5 plane 1 waits for plane 0", done_cyc[9] - done_cyc[8], TR + 2);
        clear_log();
        send(2'b00, 1, 0, 1, 3, 10, a);
        send(2'b00, 1, 0, 1, 0, 11, b);
        wait_tag(11);
        check("R5 plane 0 waits for plane 3", done_cyc[11] - done_cyc[10], TR + 2);
    endtask

    task automatic t_dies();
        int a, b;
        clear_log();
        send(2'b00, 0, 1, 0, 1, 10, a);
        send(2'b00, 0, 1, 1, 1, 11, b);
        wait_tag(11); wait_tag(10);
        check("R6 other die concurrent", done_cyc[11] - b, TR + 2);
    endtask

    task automatic t_gang();
        int a, b;
        clear_log();
        send(2'b00, 0, 0, 0, 0, 12, a);
        send(2'b00, 0, 1, 0, 0, 13, b);
        wait_tag(13);
        check("R7 same gang serialized", done_cyc[13] - done_cyc[12], TR + 2);
        clear_log();
        send(2'b00, 0, 0, 0, 0, 14, a);
        send(2'b00, 1, 0, 0, 0, 15, b);
        wait_tag(15); wait_tag(14);
        check("R7 other gang concurrent", done_cyc[15] - b, TR + 2);
    endtask

    task automatic t_bypass();
        int a, b, c;
        clear_log();
        send(2'b01, 0, 0, 0, 0, 1, a);
        send(2'b00, 0, 0, 0, 1, 2, b);
        send(2'b00, 0, 0, 1, 0, 3, c);
        wait_tag(3);
        check("R8 younger passes blocked", done_cyc[3] - c, TR + 2);
        check("R8 older not yet done", done_cyc[2], -1);
        wait_tag(2);
        check("R8 blocked after blocker", done_cyc[2] - done_cyc[1], TR + 2);
    endtask

    task automatic t_error();
        int a, b;
        clear_log();
        send(2'b00, 0, 0, 2, 0, 4, a); wait_tag(4);
        check("R9 bad die latency", done_cyc[4] - a, 2);
        check("R9 bad die flag", int'(done_e[4]), 1);
        send(2'b01, 0, 0, 0, 5, 5, a); wait_tag(5);
        check("R9 bad plane flag", int'(done_e[5]), 1);
        check("R9 bad plane latency", done_cyc[5] - a, 2);
        send(2'b11, 0, 0, 0, 0, 6, a);
        send(2'b00, 0, 0, 0, 0, 7, b);
        wait_tag(7);
        check("R9 reserved op flag", int'(done_e[6]), 1);
        check("R9 reject leaves plane free", done_cyc[7] - b, TR + 2);
        check("R9 good command no err", int'(done_e[7]), 0);
    endtask

    task automatic t_full_reset();
        int a, n0;
        clear_log();
        send(2'b10, 0, 0, 0, 0, 8, a);
        for (int t = 9; t <= 12; t++) send(2'b00, 0, 0, 0, 0, t, a);
        check("R1 ready low when full", int'(cmd_ready), 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n0 = done_cnt;
        check("R1 ready after mid-run reset", int'(cmd_ready), 1);
        repeat (3200) @(negedge clk);
        check("R10 dropped work never completes", done_cnt - n0, 0);
        send(2'b00, 0, 0, 0, 0, 13, a); wait_tag(13);
        check("R10 plane free after reset", done_cyc[13] - a, TR + 2);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                nchk++;
                nerr++;
                $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
                $display("Result: errors=%0d of %0d checks", nerr, nchk);
                $finish;
            end
        join_none
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_single();
        t_same_plane();
        t_pair();
        t_nonpair();
        t_dies();
        t_gang();
        t_bypass();
        t_error();
        t_full_reset();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule